// File: doc/BRIEF.md
# Pipeline hazard and forwarding unit

This block is the hazard-control logic for a five-stage in-order integer pipeline: fetch, decode, execute, memory access and writeback, with separate instruction and data memory ports. It compares the execute-stage source indices with the destinations held in the memory and writeback stage registers, and picks a bypass source for each ALU operand. Ordinary ALU-to-ALU dependencies then run at one instruction per clock.

Two producers deliver their result too late to bypass into the very next instruction: a load, whose data comes from memory, and a CSR instruction, whose read value appears only alongside the memory-access stage. When the decode-stage instruction reads a register that such a producer in execute will write, the unit holds fetch and decode and turns the execute slot into a no-op for one cycle. Branches and jumps resolve in execute without prediction, so a taken one flushes the two younger slots.

A data-memory wait request freezes every stage register. A trap at writeback flushes all younger stages and overrides every other decision in that cycle. The asynchronous reset is released through a short synchroniser, and the pipeline is kept flushed until that release completes. The surrounding datapath uses the outputs as stage-register clock enables and no-op selects.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: An execute-stage source that matches a writing memory-stage destination selects code 01 on its forward output, and one that matches a writing writeback-stage destination selects code 10. An ALU producer (neither load nor CSR) never causes a stall for the following instruction.
- R2: When both the memory and the writeback stage write the same source register, the memory stage (code 01) wins. A destination whose write flag is 0 is never a bypass source.
- R3: A source of register 0 always gives code 00 (register file), even if a later stage names register 0 as a written destination.
- R4: If the execute instruction is a writing load with a nonzero destination that equals a decode source whose use flag is set, bubble_ex and hold_front are 1.
- R5: A writing CSR instruction in execute causes the same one-cycle stall as a load under the same matching rule.
- R6: No stall is raised when the matching decode source has its use flag at 0, when the producer destination is register 0, or when the producer write flag is 0.
- R7: A taken redirect in execute sets flush_id and flush_ex, leaves flush_ma at 0, and causes no hold or bubble.
- R8: dmem_wait sets freeze and hold_front, forces bubble_ex to 0 and defers a redirect flush (flush_id, flush_ex at 0) while it lasts.
- R9: wb_trap sets flush_id, flush_ex and flush_ma, and forces freeze, hold_front, bubble_ex and both forward selects to 0, whatever the other inputs are.
- R10: While rst_n is low, and until the second rising clock edge after its release, the outputs are as under R9 even if dmem_wait is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the reset synchroniser |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_W | Decode-stage first source index |
| id_rs2 | input | REG_W | Decode-stage second source index |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| ex_rs1 | input | REG_W | Execute-stage first source index |
| ex_rs2 | input | REG_W | Execute-stage second source index |
| ex_rd | input | REG_W | Execute-stage destination index |
| ex_wen | input | 1 | Execute instruction writes its destination |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_csr | input | 1 | Execute instruction returns a CSR value |
| ex_redirect | input | 1 | Taken branch or jump resolved in execute |
| mem_rd | input | REG_W | Memory-stage destination index |
| mem_wen | input | 1 | Memory-stage instruction writes its destination |
| wb_rd | input | REG_W | Writeback-stage destination index |
| wb_wen | input | 1 | Writeback-stage instruction writes its destination |
| wb_trap | input | 1 | Trap taken at writeback |
| dmem_wait | input | 1 | Data-memory wait request |
| fwd_a | output | 2 | First operand source: 00 register file, 01 memory stage, 10 writeback stage |
| fwd_b | output | 2 | Second operand source, same coding |
| freeze | output | 1 | Hold every stage register |
| hold_front | output | 1 | Hold the fetch PC and decode register |
| bubble_ex | output | 1 | Load a no-op into the execute register |
| flush_id | output | 1 | Load a no-op into the decode register |
| flush_ex | output | 1 | Load a no-op into the execute register (flush) |
| flush_ma | output | 1 | Load a no-op into the memory-stage register |

## Verification
A wrong forward choice shows in the same cycle as a select code that names an older or unwritten stage, and in a real pipeline as a stale operand for one instruction. A missing stall pairs bubble_ex at 0 with a load or CSR producer whose destination matches a used decode source. A wrong priority among wait, redirect and trap shows as flush and freeze outputs that are set together. All of these outputs are combinational. Only the reset release lags, by exactly two clock edges.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;

  typedef struct packed {
    logic freeze;
    logic hold_front;
    logic bubble_ex;
    logic flush_id;
    logic flush_ex;
    logic flush_ma;
  } pipe_ctl_t;

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  input  logic             kill,
  output fwd_sel_e         sel
);

  logic src_live;
  logic hit_mem;
  logic hit_wb;

  always_comb begin
    src_live = (src != '0) && !kill;
    hit_mem  = src_live && mem_wen && (mem_rd == src);
    hit_wb   = src_live && wb_wen && (wb_rd == src);
    // youngest producer first
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end

endmodule

// File: rtl/hz_use_detect.sv
module hz_use_detect #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_late,
  output logic             use_hit
);

  logic producer_ok;
  logic match_1;
  logic match_2;

  always_comb begin
    producer_ok = ex_wen && ex_late && (ex_rd != '0);
    match_1     = id_use_rs1 && (id_rs1 == ex_rd);
    match_2     = id_use_rs2 && (id_rs2 == ex_rd);
    use_hit     = producer_ok && (match_1 || match_2);
  end

endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter
  import hz_pkg::*;
(
  input  logic      run,
  input  logic      trap,
  input  logic      mem_wait,
  input  logic      use_hit,
  input  logic      redirect,
  output pipe_ctl_t ctl
);

  logic flush_all;

  always_comb begin
    flush_all      = trap || !run;
    ctl.freeze     = mem_wait && !flush_all;
    ctl.bubble_ex  = use_hit && !mem_wait && !flush_all;
    ctl.hold_front = ctl.freeze || ctl.bubble_ex;
    ctl.flush_id   = flush_all || (redirect && !mem_wait);
    ctl.flush_ex   = flush_all || (redirect && !mem_wait);
    ctl.flush_ma   = flush_all;
  end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic             ex_is_csr,
  input  logic             ex_redirect,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  input  logic             wb_trap,
  input  logic             dmem_wait,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             freeze,
  output logic             hold_front,
  output logic             bubble_ex,
  output logic             flush_id,
  output logic             flush_ex,
  output logic             flush_ma
);

  localparam int N_OPND = 2;
  localparam int SYNC_W = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  // reset release synchroniser
  logic [SYNC_W-1:0] sync_q;
  logic [SYNC_W-1:0] sync_d;
  logic              run;

  always_comb begin
    sync_d = {sync_q[SYNC_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[SYNC_W-1];

  // operand bypass selection
  logic [REG_W-1:0] src_arr [N_OPND];
  fwd_sel_e         sel_arr [N_OPND];
  logic             fwd_kill;

  assign src_arr[0] = ex_rs1;
  assign src_arr[1] = ex_rs2;
  assign fwd_kill   = wb_trap || !run;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    hz_fwd_pick #(.REG_W(REG_W)) u_pick (
      .src     (src_arr[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .kill    (fwd_kill),
      .sel     (sel_arr[g])
    );
  end

  assign fwd_a = sel_arr[0];
  assign fwd_b = sel_arr[1];

  // late-result use detection (load data, CSR read value)
  logic use_hit;

  hz_use_detect #(.REG_W(REG_W)) u_use (
    .id_rs1     (id_rs1),
    .id_rs2     (id_rs2),
    .id_use_rs1 (id_use_rs1),
    .id_use_rs2 (id_use_rs2),
    .ex_rd      (ex_rd),
    .ex_wen     (ex_wen),
    .ex_late    (ex_is_load || ex_is_csr),
    .use_hit    (use_hit)
  );

  // stall / flush priority
  pipe_ctl_t ctl;

  hz_arbiter u_arb (
    .run      (run),
    .trap     (wb_trap),
    .mem_wait (dmem_wait),
    .use_hit  (use_hit),
    .redirect (ex_redirect),
    .ctl      (ctl)
  );

  assign freeze     = ctl.freeze;
  assign hold_front = ctl.hold_front;
  assign bubble_ex  = ctl.bubble_ex;
  assign flush_id   = ctl.flush_id;
  assign flush_ex   = ctl.flush_ex;
  assign flush_ma   = ctl.flush_ma;

endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] ex_rs1,
  input logic [REG_W-1:0] ex_rs2,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_wen,
  input logic             ex_is_load,
  input logic             ex_is_csr,
  input logic             ex_redirect,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_wen,
  input logic             wb_trap,
  input logic             dmem_wait,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             freeze,
  input logic             hold_front,
  input logic             bubble_ex,
  input logic             flush_id,
  input logic             flush_ex,
  input logic             flush_ma
);

  p_mem_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_ma && mem_wen && (mem_rd == ex_rs1) && (ex_rs1 != '0)) |-> (fwd_a == 2'b01));

  p_zero_src_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> (fwd_a == 2'b00));

  p_zero_src_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs2 == '0) |-> (fwd_b == 2'b00));

  p_bubble_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |-> (hold_front && ex_wen && (ex_is_load || ex_is_csr) && (ex_rd != '0)));

  p_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_redirect && !dmem_wait) |-> (flush_id && flush_ex));

  p_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_wait && !flush_ma) |-> (freeze && hold_front && !bubble_ex && !flush_id));

  p_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_trap |-> (flush_id && flush_ex && flush_ma && !freeze && !hold_front
                 && !bubble_ex && (fwd_a == 2'b00) && (fwd_b == 2'b00)));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flush_ma && !freeze));

endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/pipe_hazard_ctrl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_test;

  localparam int RW = 5;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use_rs1, id_use_rs2, ex_wen, ex_is_load, ex_is_csr, ex_redirect;
  logic mem_wen, wb_wen, wb_trap, dmem_wait;
  logic [1:0] fwd_a, fwd_b;
  logic freeze, hold_front, bubble_ex, flush_id, flush_ex, flush_ma;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pipe_hazard_ctrl #(.REG_W(RW), .SYNC_STAGES(2)) uut (.*);

  // {id_rs1,id_rs2,use1,use2, ex_rs1,ex_rs2,ex_rd, wen,load,csr,redirect,
  //  mem_rd,mem_wen, wb_rd,wb_wen, trap,wait,
  //  exp fwd_a,fwd_b, exp freeze,hold,bubble,flush_id,flush_ex,flush_ma, req}
  localparam logic [58:0] TBL [NV] = '{
    {5'd0,5'd0,2'b00, 5'd3,5'd4,5'd7,  4'b1000, 5'd3,1'b1, 5'd4,1'b1, 2'b00, 2'b01,2'b10, 6'b000000, 4'd1}, // R1 both sources
    {5'd8,5'd0,2'b10, 5'd1,5'd2,5'd8,  4'b1000, 5'd0,1'b0, 5'd0,1'b0, 2'b00, 2'b00,2'b00, 6'b000000, 4'd1}, // R1 ALU no stall
    {5'd0,5'd0,2'b00, 5'd5,5'd5,5'd7,  4'b1000, 5'd5,1'b1, 5'd5,1'b1, 2'b00, 2'b01,2'b01, 6'b000000, 4'd2}, // R2 mem wins
    {5'd0,5'd0,2'b00, 5'd6,5'd9,5'd7,  4'b1000, 5'd6,1'b0, 5'd6,1'b1, 2'b00, 2'b10,2'b00, 6'b000000, 4'd2}, // R2 no wen at mem
    {5'd0,5'd0,2'b00, 5'd0,5'd0,5'd7,  4'b1000, 5'd0,1'b1, 5'd0,1'b1, 2'b00, 2'b00,2'b00, 6'b000000, 4'd3}, // R3 x0
    {5'd8,5'd0,2'b10, 5'd1,5'd2,5'd8,  4'b1100, 5'd0,1'b0, 5'd0,1'b0, 2'b00, 2'b00,2'b00, 6'b011000, 4'd4}, // R4 rs1
    {5'd3,5'd8,2'b01, 5'd1,5'd2,5'd8,  4'b1100, 5'd0,1'b0, 5'd0,1'b0, 2'b00, 2'b00,2'b00, 6'b011000, 4'd4}, // R4 rs2
    {5'd12,5'd0,2'b10,5'd1,5'd2,5'd12, 4'b1010, 5'd0,1'b0, 5'd0,1'b0, 2'b00, 2'b00,2'b00, 6'b011000, 4'd5}, // R5 csr
    {5'd8,5'd8,2'b00, 5'd1,5'd2,5'd8,  4'b1100, 5'd0,1'b0, 5'd0,1'b0, 2'b00, 2'b00,2'b00, 6'b000000, 4'd6}, // R6 unused
    {5'd0,5'd0,2'b11, 5'd1,5'd2,5'd0,  4'b1100, 5'd0,1'b0, 5'd0,1'b0, 2'b00, 2'b00,2'b00, 6'b000000, 4'd6}, // R6 rd x0
    {5'd8,5'd0,2'b10, 5'd1,5'd2,5'd8,  4'b0100, 5'd0,1'b0, 5'd0,1'b0, 2'b00, 2'b00,2'b00, 6'b000000, 4'd6}, // R6 no wen
    {5'd0,5'd0,2'b00, 5'd1,5'd2,5'd0,  4'b0001, 5'd0,1'b0, 5'd0,1'b0, 2'b00, 2'b00,2'b00, 6'b000110, 4'd7}, // R7 redirect
    {5'd8,5'd0,2'b10, 5'd1,5'd2,5'd8,  4'b1101, 5'd0,1'b0, 5'd0,1'b0, 2'b01, 2'b00,2'b00, 6'b110000, 4'd8}, // R8 wait wins
    {5'd8,5'd0,2'b10, 5'd3,5'd3,5'd8,  4'b1101, 5'd3,1'b1, 5'd3,1'b1, 2'b11, 2'b00,2'b00, 6'b000111, 4'd9}  // R9 trap wins
  };

  task automatic drive(input logic [58:0] v);
    {id_rs1, id_rs2, id_use_rs1, id_use_rs2} = v[58:47];
    {ex_rs1, ex_rs2, ex_rd}                  = v[46:32];
    {ex_wen, ex_is_load, ex_is_csr, ex_redirect} = v[31:28];
    {mem_rd, mem_wen, wb_rd, wb_wen}         = v[27:16];
    {wb_trap, dmem_wait}                     = v[15:14];
  endtask

  task automatic check(input int req, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] outs();
    return {fwd_a, fwd_b, freeze, hold_front, bubble_ex, flush_id, flush_ex, flush_ma};
  endfunction

  initial begin
    drive(59'd0);
    // R10: reset state, wait request ignored during reset
    dmem_wait = 1'b1;
    #5;
    check(10, "in reset", outs(), 10'b0000_000111);
    @(negedge clk);
    rst_n = 1'b1;
    dmem_wait = 1'b0;
    @(posedge clk); #5;
    check(10, "one edge after release", outs(), 10'b0000_000111);
    @(posedge clk); #5;
    check(10, "two edges after release", outs(), 10'b0000_000000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #5;
      check(int'(TBL[i][3:0]), $sformatf("vector %0d", i), outs(), TBL[i][13:4]);
    end

    // R10: reset asserted again mid-run overrides a forwarding match
    @(negedge clk);
    drive(TBL[0]);
    rst_n = 1'b0;
    #2;
    check(10, "reassert overrides forward", outs(), 10'b0000_000111);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); #5;
    check(1, "forward resumes after release", outs(), 10'b0110_000000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule